// File: doc/BRIEF.md
# Complementary Drive Deadtime Generator

The block turns one main pulse-width command into two gate-control outputs. The main output follows the command and drives the primary switch. The auxiliary output is its complement and is on during the main switch's off time. A non-overlap gap, in which both outputs are off, separates every pair of transitions. The two gaps are timed on their own: `dly_on_i` sets the gap from auxiliary-off to main-on, and `dly_aux_i` sets the gap from main-off to auxiliary-on. Both are counts of system clock cycles, and a value of zero is treated as one cycle.

While `run_i` is low, both outputs stay off. An auxiliary phase that sees no new command pulse within `AUX_MAX` cycles is treated as zero duty, and both outputs then go off. While `fault_i` is high, the main output is held off. The auxiliary output keeps switching from the rising edges of the command. After each rising edge it stays off for the sum of the two gaps and is on for the rest of the period.

A strap input `aux_inv_i` selects the electrical sense of the auxiliary output: active-low for a P-type switch or active-high for an N-type switch. The command is sampled on the clock. The outputs are decoded from a registered state.

Top module: `cdt_gen`

## Requirements
- R1: The main output and the auxiliary output are never both in their on state in the same cycle. Every rise of either output is preceded by a cycle in which the other output was off.
- R2: In steady operation the main output is a pulse of H-E1 cycles for a command pulse of H cycles with H > E1. E1 is the effective `dly_on_i`. A request that arrives while the gap before main-on is running is kept, and it is served when the gap expires.
- R3: The auxiliary output turns on E2 cycles after the main output turns off, where E2 is the effective `dly_aux_i`. In a period whose command low time is L, with E2 < L, the auxiliary output is on for L-E2 cycles, capped at `AUX_MAX`.
- R4: A delay input of zero behaves exactly like a delay input of one.
- R5: A command pulse of at most E1 cycles never turns the main output on. The auxiliary output comes back on after its E1-cycle off gap.
- R6: Out of reset, and in the cycle after `run_i` is sampled low, both outputs are off.
- R7: An auxiliary on-phase lasts at most `AUX_MAX` cycles, after which both outputs are off. From that idle state, a command that is sampled high turns the main output on at the next edge, with no gap, and the main pulse lasts the full H cycles.
- R8: While `fault_i` is high, the main output is off from the next edge on. Each command rising edge turns the auxiliary output off for E1+E2 cycles, after which it stays on until the next rising edge.
- R9: With `aux_inv_i`=1 the auxiliary output is high when on. With `aux_inv_i`=0 it is low when on. The main output is always active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | Main pulse-width command |
| run_i | input | 1 | Startup complete; low forces both outputs off |
| fault_i | input | 1 | Fault or shutdown; main held off, auxiliary free-runs |
| dly_on_i | input | DW | Gap from auxiliary-off to main-on, cycles (0 treated as 1) |
| dly_aux_i | input | DW | Gap from main-off to auxiliary-on, cycles (0 treated as 1) |
| aux_inv_i | input | 1 | Auxiliary sense: 1 active-high, 0 active-low |
| main_o | output | 1 | Main switch drive, active-high |
| aux_o | output | 1 | Auxiliary switch drive, sense set by aux_inv_i |

## Verification
The bench sweeps both delays from zero upward, with pulse widths on either side of the main-on gap. In every period it compares the on-cycles of each output with H-E1 and L-E2. A design that drops a request arriving inside the gap would show an empty main period. A design that does not turn a zero delay into one cycle would show counts off by one, or overlap. Toggling the auxiliary sense on every configuration exposes an inverted or non-inverted decode as wrong counts and as apparent overlap. Separate phases drive a long low command to hit the zero-duty timeout and then check that the restart from idle skips the gap. They also check, in fault mode, that the main output stays off and the auxiliary off window equals the sum of the gaps.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // both off
    ST_MAIN,  // main on
    ST_DT2,   // gap main-off -> aux-on
    ST_AUX,   // aux on
    ST_DT1,   // gap aux-off -> main-on
    ST_FOFF   // fault-mode aux off window
  } cdt_state_e;
endpackage

// File: rtl/cdt_dly_norm.sv
module cdt_dly_norm #(
  parameter int DW = 8,
  parameter int CW = 9
) (
  input  logic [DW-1:0] d1_i,
  input  logic [DW-1:0] d2_i,
  output logic [CW-1:0] ld_d1_o,
  output logic [CW-1:0] ld_d2_o,
  output logic [CW-1:0] ld_sum_o
);
  localparam int PADW = CW - DW;

  logic [CW-1:0] e1, e2;

  // zero coerced to one cycle
  assign e1 = (d1_i == '0) ? CW'(1) : {{PADW{1'b0}}, d1_i};
  assign e2 = (d2_i == '0) ? CW'(1) : {{PADW{1'b0}}, d2_i};

  assign ld_d1_o  = e1 - CW'(1);
  assign ld_d2_o  = e2 - CW'(1);
  assign ld_sum_o = e1 + e2 - CW'(1);
endmodule

// File: rtl/cdt_fsm.sv
module cdt_fsm
  import cdt_pkg::*;
#(
  parameter int CW      = 9,
  parameter int AUX_MAX = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwm_i,
  input  logic          run_i,
  input  logic          fault_i,
  input  logic [CW-1:0] ld_d1_i,
  input  logic [CW-1:0] ld_d2_i,
  input  logic [CW-1:0] ld_sum_i,
  output logic          main_on_o,
  output logic          aux_on_o
);
  localparam logic [CW-1:0] LD_AUX = CW'(AUX_MAX - 1);

  cdt_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pwm_q;
  logic          rise, cnt_zero, req;

  assign rise     = pwm_i & ~pwm_q;
  assign cnt_zero = (cnt_q == '0);
  assign req      = pwm_i & ~fault_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_zero ? cnt_q : cnt_q - CW'(1);
    if (!run_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (fault_i && rise) begin
            st_d = ST_FOFF; cnt_d = ld_sum_i;
          end else if (req) begin
            st_d = ST_MAIN;
          end
        end
        ST_MAIN: begin
          if (!req) begin
            st_d = ST_DT2; cnt_d = ld_d2_i;
          end
        end
        ST_DT2: begin
          if (cnt_zero) begin
            if (req) begin
              st_d = ST_DT1; cnt_d = ld_d1_i;
            end else begin
              st_d = ST_AUX; cnt_d = LD_AUX;
            end
          end
        end
        ST_AUX: begin
          if (fault_i && rise) begin
            st_d = ST_FOFF; cnt_d = ld_sum_i;
          end else if (req) begin
            st_d = ST_DT1; cnt_d = ld_d1_i;
          end else if (cnt_zero) begin
            st_d = ST_IDLE;  // zero duty
          end
        end
        ST_DT1: begin
          if (cnt_zero) begin
            if (req) begin
              st_d = ST_MAIN;
            end else begin
              st_d = ST_AUX; cnt_d = LD_AUX;
            end
          end
        end
        ST_FOFF: begin
          if (cnt_zero) begin
            st_d = ST_AUX; cnt_d = LD_AUX;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pwm_q <= pwm_i;
    end
  end

  assign main_on_o = (st_q == ST_MAIN);
  assign aux_on_o  = (st_q == ST_AUX);

  // R1
  main_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_on_o) |-> $past(!aux_on_o));
  // R1
  aux_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_on_o) |-> $past(!main_on_o));
  // R8
  fault_main_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !main_on_o);
  // R6
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!main_on_o && !aux_on_o));
  // R7
  idle_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && run_i && !fault_i && pwm_i) |=> main_on_o);
endmodule

// File: rtl/cdt_gen.sv
module cdt_gen #(
  parameter int DW      = 8,
  parameter int AUX_MAX = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwm_i,
  input  logic          run_i,
  input  logic          fault_i,
  input  logic [DW-1:0] dly_on_i,
  input  logic [DW-1:0] dly_aux_i,
  input  logic          aux_inv_i,
  output logic          main_o,
  output logic          aux_o
);
  localparam int AW = $clog2(AUX_MAX + 1);
  localparam int CW = (AW > DW + 1) ? AW : DW + 1;

  logic [CW-1:0] ld_d1, ld_d2, ld_sum;
  logic          main_on, aux_on;

  cdt_dly_norm #(.DW(DW), .CW(CW)) u_dly (
    .d1_i    (dly_on_i),
    .d2_i    (dly_aux_i),
    .ld_d1_o (ld_d1),
    .ld_d2_o (ld_d2),
    .ld_sum_o(ld_sum)
  );

  cdt_fsm #(.CW(CW), .AUX_MAX(AUX_MAX)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwm_i    (pwm_i),
    .run_i    (run_i),
    .fault_i  (fault_i),
    .ld_d1_i  (ld_d1),
    .ld_d2_i  (ld_d2),
    .ld_sum_i (ld_sum),
    .main_on_o(main_on),
    .aux_on_o (aux_on)
  );

  assign main_o = main_on;
  // R9: inverted strap gives active-high aux
  assign aux_o  = aux_inv_i ? aux_on : ~aux_on;
endmodule

// File: tb/cdt_gen_bench.sv
module cdt_gen_bench;
  localparam int DW   = 4;
  localparam int AMAX = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm = 1'b0, run = 1'b0, fault = 1'b0, inv = 1'b0;
  logic [DW-1:0] d1 = '0, d2 = '0;
  logic          main_o, aux_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cdt_gen #(.DW(DW), .AUX_MAX(AMAX)) u_cdt_gen (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .run_i(run), .fault_i(fault),
    .dly_on_i(d1), .dly_aux_i(d2), .aux_inv_i(inv),
    .main_o(main_o), .aux_o(aux_o)
  );

  function automatic int eff(int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one command period from a negedge; sample i reflects the edge that saw pwm(i)
  task automatic period(int h, int l, int exp_m, int exp_a, string req);
    int nm = 0;
    int na = 0;
    for (int i = 0; i < h + l; i++) begin
      pwm = (i < h);
      @(negedge clk);
      if (main_o) nm++;
      if (aux_o == inv) na++;
      if (main_o && (aux_o == inv)) check("R1 overlap", 1, 0);
    end
    check({req, " main"}, nm, exp_m);
    check({req, " aux"}, na, exp_a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e1, e2;
    repeat (3) @(negedge clk);
    // R6 reset state
    check("R6 reset main", int'(main_o), 0);
    check("R9 reset aux idle level", int'(aux_o), 1);
    rst_n = 1'b1;
    run   = 1'b1;
    @(negedge clk);
    check("R6 idle main", int'(main_o), 0);

    // warmup from idle
    d1 = 4'd1; d2 = 4'd2;
    period(5, 6, 5, 4, "R7 first");

    // normal sweep, R2 R3 R4 R5 R9
    for (int a = 0; a < 4; a++) begin
      for (int b = a; b < a + 4; b++) begin
        d1 = DW'(a); d2 = DW'(b);
        inv = ((a + b) % 2) == 1;
        e1 = eff(a); e2 = eff(b);
        for (int h = 1; h <= 6; h++) begin
          for (int l = e2 + 1; l <= e2 + 3; l++) begin
            if (h > e1) period(h, l, h - e1, imin(l - e2, AMAX), "R2 R3 R4");
            else        period(h, l, 0, imin(h + l - e1, AMAX), "R5 R4");
          end
        end
      end
    end

    // zero duty timeout then restart from idle, R7
    inv = 1'b0; d1 = 4'd1; d2 = 4'd2;
    period(4, 6, 3, 4, "R3 pre");
    period(4, 60, 3, AMAX, "R7 timeout");
    check("R7 idle aux", int'(aux_o == inv), 0);
    period(5, 6, 5, 4, "R7 restart");

    // fault mode, R8
    fault = 1'b1;
    d1 = 4'd1; d2 = 4'd2;
    period(6, 6, 0, 12 - 3, "R8 warm");
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 4; b++) begin
        d1 = DW'(a); d2 = DW'(b);
        inv = (b % 2) == 0;
        e1 = eff(a); e2 = eff(b);
        period(5, 7, 0, 12 - e1 - e2, "R8 fault");
        period(2, 9, 0, 11 - e1 - e2, "R8 fault short");
      end
    end
    fault = 1'b0;
    inv = 1'b1;
    d1 = 4'd2; d2 = 4'd3;
    period(4, 6, 2, 3, "R8 release");

    // run drop mid main pulse, R6
    pwm = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 main before drop", int'(main_o), 1);
    run = 1'b0;
    @(negedge clk);
    check("R6 drop main", int'(main_o), 0);
    check("R6 drop aux", int'(aux_o == inv), 0);
    @(negedge clk);
    check("R6 held main", int'(main_o), 0);
    pwm = 1'b0;
    run = 1'b1;
    period(5, 6, 5, 3, "R7 after run");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule